// File: doc/BRIEF.md
# Flash completion polling controller

This block sits on the host side of an 8-bit asynchronous parallel NOR flash bus. It accepts one request at a time. A request is either a byte program or a sector erase, and carries a target address, write data and two per-request options: the completion-detection method and whether a verify read follows. The block sends the unlock and command write cycles for the requested operation. It then reads the target address repeatedly until the flash reports that its internal operation has finished.

Completion is detected in one of two ways, chosen per request:

- **Data polling.** Bit 7 of the read data is compared with the value expected once the operation has finished.
- **Toggle detection.** Bit 6 of two consecutive reads is compared, and the operation is finished when they match.

If the flash never reports completion within a fixed number of reads, the request ends with a timeout error. When the verify option is enabled, the block waits a settling interval after completion and then performs one full-byte read. That read is compared with the programmed byte, or with 0xFF after an erase. The request ends with a one-cycle `done` pulse, and the two error flags are valid from that cycle onward.

The sequencer states are:

| State | Purpose |
|---|---|
| S_IDLE | Waiting for a request |
| S_WRITE | Command write cycles |
| S_POLL | Status reads |
| S_SETTLE | Settling wait |
| S_VERIFY | Full-byte read |
| S_FINISH | `done` pulse |

Its transitions are:

- **accept:** S_IDLE to S_WRITE on `req_valid`.
- **last_write:** S_WRITE to S_POLL when the final command cycle completes.
- **complete_verify:** S_POLL to S_SETTLE.
- **complete_noverify:** S_POLL to S_FINISH.
- **poll_timeout:** S_POLL to S_FINISH.
- **settled:** S_SETTLE to S_VERIFY.
- **verified:** S_VERIFY to S_FINISH.
- **release:** S_FINISH to S_IDLE.

The bus-cycle engine moves through B_IDLE, B_SETUP, B_STROBE and B_RECOV for every single read or write cycle.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset and whenever `busy` is 0, the flash bus is idle: `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1 and `fl_dq_oe` is 0. `done` is 0 after reset.
- R2: A program request (`req_erase`=0) issues exactly four write cycles, as (address, data) pairs in this order: (UNLOCK_A, 0xAA), (UNLOCK_B, 0x55), (UNLOCK_A, 0xA0), (`req_addr`, `req_data`). Each `fl_we_n` low pulse lasts exactly WR_PULSE clock cycles, and `fl_dq_oe` is 1 while `fl_we_n` is low.
- R3: An erase request (`req_erase`=1) issues exactly six write cycles, in this order: (UNLOCK_A, 0xAA), (UNLOCK_B, 0x55), (UNLOCK_A, 0x80), (UNLOCK_A, 0xAA), (UNLOCK_B, 0x55), (`req_addr`, 0x30).
- R4: No read strobe occurs before the last command write cycle has ended. Every status and verify read uses `req_addr`.
- R5: With `req_poll_toggle`=0, a program is complete at the first read whose bit 7 equals `req_data[7]`. An erase is complete at the first read whose bit 7 is 1.
- R6: With `req_poll_toggle`=1, the operation is complete at the first read whose bit 6 equals bit 6 of the read just before it. The first status read of a request therefore never completes it.
- R7: If MAX_POLLS status reads pass without completion, the request ends with `timeout_err`=1 and no verify read.
- R8: With `req_verify`=1, the verify read strobe starts at least SETTLE_CYC clock cycles after the completing status read strobe ends. `verify_err` is set when the byte read differs from `req_data` (program) or 0xFF (erase). With `req_verify`=0 no verify read is made and `verify_err` stays 0.
- R9: `done` is high for exactly one clock cycle per accepted request. `timeout_err` and `verify_err` keep their values until the next request is accepted, which clears them.
- R10: `req_valid` is accepted only when `busy` is 0. A request presented while busy has no effect on the bus cycles or on the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_erase | input | 1 | 1 = sector erase, 0 = byte program |
| req_poll_toggle | input | 1 | 1 = toggle detection on bit 6, 0 = data polling on bit 7 |
| req_verify | input | 1 | 1 = settle and perform a full-byte verify read |
| req_addr | input | AW | Target byte address or sector address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| timeout_err | output | 1 | Last request hit the poll limit |
| verify_err | output | 1 | Last request's verify read mismatched |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Enables the data drivers |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| fl_ce_n | output | 1 | Chip select, active low |

## Verification
Two situations are hard to reach from the ports. One is a flash that stays busy for a chosen number of reads and then finishes, or never finishes at all. The other is the toggle case where the first true-data read does not yet match the last busy read. The bench holds a small flash model that counts read strobes. For a set number of reads it returns complemented or zero bit 7 together with a bit 6 that flips on every read, and after that it returns a chosen stored byte. This lets each test place completion, timeout and verify mismatch on an exact read. The model also timestamps every strobe edge, so the settle gap and the write pulse width are measured directly on the pins.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_POLL,
        S_SETTLE,
        S_VERIFY,
        S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_SETUP,
        B_STROBE,
        B_RECOV
    } bus_state_t;

    typedef enum logic [1:0] {
        AS_UNLOCK_A,
        AS_UNLOCK_B,
        AS_TARGET
    } addr_sel_t;

    typedef struct packed {
        addr_sel_t  sel;
        logic [7:0] data;
    } cmd_step_t;

    localparam int PROG_STEPS  = 4;
    localparam int ERASE_STEPS = 6;

    // Command step table: the order of the unlock cycles is protocol behaviour.
    function automatic cmd_step_t cmd_step(input logic erase,
                                           input logic [2:0] idx,
                                           input logic [7:0] wdata);
        cmd_step_t s;
        s.sel  = AS_UNLOCK_A;
        s.data = 8'hAA;
        unique case (idx)
            3'd0: begin s.sel = AS_UNLOCK_A; s.data = 8'hAA; end
            3'd1: begin s.sel = AS_UNLOCK_B; s.data = 8'h55; end
            3'd2: begin s.sel = AS_UNLOCK_A; s.data = erase ? 8'h80 : 8'hA0; end
            3'd3: begin
                if (erase) begin s.sel = AS_UNLOCK_A; s.data = 8'hAA;  end
                else       begin s.sel = AS_TARGET;   s.data = wdata;  end
            end
            3'd4: begin s.sel = AS_UNLOCK_B; s.data = 8'h55; end
            3'd5: begin s.sel = AS_TARGET;   s.data = 8'h30; end
            default: begin s.sel = AS_UNLOCK_A; s.data = 8'hAA; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fpc_bus_cycle.sv
module fpc_bus_cycle #(
    parameter int AW       = 19,
    parameter int WR_PULSE = 4,
    parameter int RD_PULSE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_read,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    wdata_in,
    output logic          cyc_done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic          fl_ce_n
);
    import flash_poll_pkg::*;

    localparam int MAXP = (WR_PULSE > RD_PULSE) ? WR_PULSE : RD_PULSE;
    localparam int CW   = $clog2(MAXP + 1);

    bus_state_t    st, st_nxt;
    logic [CW-1:0] cnt;
    logic          lat_read;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_wdata;
    logic          last_beat;
    logic          nxt_read;

    assign last_beat = lat_read ? (cnt == CW'(RD_PULSE - 1))
                                : (cnt == CW'(WR_PULSE - 1));
    assign nxt_read  = (st == B_IDLE) ? is_read : lat_read;
    assign cyc_done  = (st == B_RECOV);
    assign fl_addr   = lat_addr;
    assign fl_dq_out = lat_wdata;

    always_comb begin
        st_nxt = st;
        unique case (st)
            B_IDLE:   if (start)     st_nxt = B_SETUP;
            B_SETUP:                 st_nxt = B_STROBE;
            B_STROBE: if (last_beat) st_nxt = B_RECOV;
            B_RECOV:                 st_nxt = B_IDLE;
            default:                 st_nxt = B_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= B_IDLE;
        else        st <= st_nxt;
    end

    // Datapath and registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            lat_read  <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rdata     <= '0;
            fl_we_n   <= 1'b1;
            fl_oe_n   <= 1'b1;
            fl_ce_n   <= 1'b1;
            fl_dq_oe  <= 1'b0;
        end else begin
            if (st == B_STROBE && !last_beat) cnt <= cnt + 1'b1;
            else                              cnt <= '0;
            if (st == B_IDLE && start) begin
                lat_read  <= is_read;
                lat_addr  <= addr_in;
                lat_wdata <= wdata_in;
            end
            if (st == B_STROBE && last_beat && lat_read) rdata <= fl_dq_in;
            fl_we_n  <= !(st_nxt == B_STROBE && !lat_read);
            fl_oe_n  <= !(st_nxt == B_STROBE &&  lat_read);
            fl_ce_n  <= !(st_nxt == B_SETUP || st_nxt == B_STROBE);
            fl_dq_oe <= (st_nxt != B_IDLE) && !nxt_read;
        end
    end

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    assert_write_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_dq_oe);
    assert_strobe_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

endmodule

// File: rtl/fpc_status_eval.sv
module fpc_status_eval (
    input  logic       mode_toggle,
    input  logic       op_erase,
    input  logic       exp_bit7,
    input  logic [7:0] dq,
    input  logic       prev_dq6,
    input  logic       have_prev,
    output logic       complete
);
    logic poll_hit;
    logic toggle_hit;

    assign poll_hit   = op_erase ? dq[7] : (dq[7] == exp_bit7);
    assign toggle_hit = have_prev && (dq[6] == prev_dq6);
    assign complete   = mode_toggle ? toggle_hit : poll_hit;

endmodule

// File: rtl/fpc_seq.sv
module fpc_seq #(
    parameter int AW         = 19,
    parameter int MAX_POLLS  = 65535,
    parameter int SETTLE_CYC = 50,
    parameter int UNLOCK_A   = 'h5555,
    parameter int UNLOCK_B   = 'h2AAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_erase,
    input  logic          req_poll_toggle,
    input  logic          req_verify,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          busy,
    output logic          done,
    output logic          timeout_err,
    output logic          verify_err,
    output logic          bc_start,
    output logic          bc_read,
    output logic [AW-1:0] bc_addr,
    output logic [7:0]    bc_wdata,
    input  logic          bc_done,
    input  logic [7:0]    bc_rdata
);
    import flash_poll_pkg::*;

    localparam int PCW = $clog2(MAX_POLLS + 1);
    localparam int SCW = $clog2(SETTLE_CYC + 1);

    seq_state_t     state, nxt;
    logic           op_erase, op_toggle, op_verify;
    logic [AW-1:0]  op_addr;
    logic [7:0]     op_data;
    logic [2:0]     idx;
    logic [2:0]     last_idx;
    logic [PCW-1:0] poll_cnt;
    logic [SCW-1:0] settle_cnt;
    logic           prev6, have_prev;
    logic           st_complete;
    logic           poll_last;
    cmd_step_t      step;
    logic [7:0]     verify_exp;

    assign last_idx   = op_erase ? 3'(ERASE_STEPS - 1) : 3'(PROG_STEPS - 1);
    assign poll_last  = (poll_cnt == PCW'(MAX_POLLS - 1));
    assign step       = cmd_step(op_erase, idx, op_data);
    assign verify_exp = op_erase ? 8'hFF : op_data;

    fpc_status_eval u_eval (
        .mode_toggle (op_toggle),
        .op_erase    (op_erase),
        .exp_bit7    (op_data[7]),
        .dq          (bc_rdata),
        .prev_dq6    (prev6),
        .have_prev   (have_prev),
        .complete    (st_complete)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = S_WRITE;
            S_WRITE:  if (bc_done && idx == last_idx) nxt = S_POLL;
            S_POLL: begin
                if (bc_done) begin
                    if (st_complete)    nxt = op_verify ? S_SETTLE : S_FINISH;
                    else if (poll_last) nxt = S_FINISH;
                end
            end
            S_SETTLE: if (settle_cnt == SCW'(SETTLE_CYC - 1)) nxt = S_VERIFY;
            S_VERIFY: if (bc_done) nxt = S_FINISH;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Bus requests toward the cycle engine
    always_comb begin
        bc_start = (state == S_WRITE) || (state == S_POLL) || (state == S_VERIFY);
        bc_read  = (state == S_POLL) || (state == S_VERIFY);
        bc_wdata = step.data;
        if (bc_read || step.sel == AS_TARGET) bc_addr = op_addr;
        else if (step.sel == AS_UNLOCK_B)     bc_addr = AW'(UNLOCK_B);
        else                                  bc_addr = AW'(UNLOCK_A);
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_FINISH);

    // Operation registers and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_erase    <= 1'b0;
            op_toggle   <= 1'b0;
            op_verify   <= 1'b0;
            op_addr     <= '0;
            op_data     <= '0;
            idx         <= '0;
            poll_cnt    <= '0;
            settle_cnt  <= '0;
            prev6       <= 1'b0;
            have_prev   <= 1'b0;
            timeout_err <= 1'b0;
            verify_err  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        op_erase    <= req_erase;
                        op_toggle   <= req_poll_toggle;
                        op_verify   <= req_verify;
                        op_addr     <= req_addr;
                        op_data     <= req_data;
                        idx         <= '0;
                        poll_cnt    <= '0;
                        settle_cnt  <= '0;
                        have_prev   <= 1'b0;
                        timeout_err <= 1'b0;
                        verify_err  <= 1'b0;
                    end
                end
                S_WRITE: if (bc_done && idx != last_idx) idx <= idx + 1'b1;
                S_POLL: begin
                    if (bc_done) begin
                        prev6     <= bc_rdata[6];
                        have_prev <= 1'b1;
                        if (!poll_last) poll_cnt <= poll_cnt + 1'b1;
                        if (!st_complete && poll_last) timeout_err <= 1'b1;
                    end
                end
                S_SETTLE: settle_cnt <= settle_cnt + 1'b1;
                S_VERIFY: if (bc_done) verify_err <= (bc_rdata != verify_exp);
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_timeout_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);
    assert_verify_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verify_err) |-> done);
    assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt < PCW'(MAX_POLLS));
    assert_busy_holds_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(op_addr) && $stable(op_erase) && $stable(op_data)));

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
    parameter int AW         = 19,
    parameter int WR_PULSE   = 4,
    parameter int RD_PULSE   = 4,
    parameter int SETTLE_CYC = 50,
    parameter int MAX_POLLS  = 65535,
    parameter int UNLOCK_A   = 'h5555,
    parameter int UNLOCK_B   = 'h2AAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_erase,
    input  logic          req_poll_toggle,
    input  logic          req_verify,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          busy,
    output logic          done,
    output logic          timeout_err,
    output logic          verify_err,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic          fl_ce_n
);
    logic          bc_start, bc_read, bc_done;
    logic [AW-1:0] bc_addr;
    logic [7:0]    bc_wdata, bc_rdata;

    fpc_seq #(
        .AW(AW), .MAX_POLLS(MAX_POLLS), .SETTLE_CYC(SETTLE_CYC),
        .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_erase(req_erase),
        .req_poll_toggle(req_poll_toggle), .req_verify(req_verify),
        .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .timeout_err(timeout_err), .verify_err(verify_err),
        .bc_start(bc_start), .bc_read(bc_read), .bc_addr(bc_addr), .bc_wdata(bc_wdata),
        .bc_done(bc_done), .bc_rdata(bc_rdata)
    );

    fpc_bus_cycle #(
        .AW(AW), .WR_PULSE(WR_PULSE), .RD_PULSE(RD_PULSE)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .start(bc_start), .is_read(bc_read), .addr_in(bc_addr), .wdata_in(bc_wdata),
        .cyc_done(bc_done), .rdata(bc_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n)
    );

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));

endmodule

// File: tb/flash_poll_ctrl_tb.sv
module flash_poll_ctrl_tb;
    localparam int AW         = 16;
    localparam int WR_PULSE   = 3;
    localparam int RD_PULSE   = 2;
    localparam int SETTLE_CYC = 10;
    localparam int MAX_POLLS  = 8;
    localparam int UA         = 'h5555;
    localparam int UB         = 'h2AAA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_erase = 1'b0, req_poll_toggle = 1'b0, req_verify = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          busy, done, timeout_err, verify_err;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out, fl_dq_in;
    logic          fl_dq_oe, fl_we_n, fl_oe_n, fl_ce_n;

    always #10 clk = ~clk;

    flash_poll_ctrl #(
        .AW(AW), .WR_PULSE(WR_PULSE), .RD_PULSE(RD_PULSE), .SETTLE_CYC(SETTLE_CYC),
        .MAX_POLLS(MAX_POLLS), .UNLOCK_A(UA), .UNLOCK_B(UB)
    ) u_dut (.*);

    int checks = 0, errors = 0;

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int            cyc = 0;
    always @(posedge clk) cyc++;
    int            done_cnt = 0;
    always @(posedge clk) if (rst_n && done) done_cnt++;

    logic          arm = 1'b0;
    int            wr_n, rd_n, early_rd, bad_width, bad_raddr, exp_len;
    int            we_fall, last_rise, gap_last;
    logic [AW-1:0] wr_a [0:7];
    logic [7:0]    wr_d [0:7];
    logic [AW-1:0] m_addr;
    logic          m_erase, tog;
    logic [7:0]    m_data, mem_val, rd_q;
    int            busy_left;

    assign fl_dq_in = rd_q;

    always @(negedge fl_we_n) if (arm) begin
        we_fall = cyc;
        if (wr_n < 8) begin wr_a[wr_n] = fl_addr; wr_d[wr_n] = fl_dq_out; end
    end
    always @(posedge fl_we_n) if (arm) begin
        if (cyc - we_fall != WR_PULSE) bad_width++;
        wr_n++;
    end
    always @(negedge fl_oe_n) if (arm) begin
        rd_n++;
        gap_last = cyc - last_rise;
        if (wr_n < exp_len) early_rd++;
        if (fl_addr != m_addr) bad_raddr++;
        if (busy_left > 0) begin
            busy_left--;
            tog  = ~tog;
            rd_q = {(m_erase ? 1'b0 : ~m_data[7]), tog, 6'h15};
        end else begin
            rd_q = mem_val;
        end
    end
    always @(posedge fl_oe_n) if (arm) last_rise = cyc;

    logic got_to, got_ve;

    task automatic run_op(input logic erase, input logic toggle, input logic verify,
                          input logic [AW-1:0] addr, input logic [7:0] data,
                          input int busy_reads, input logic [7:0] stored);
        wr_n = 0; rd_n = 0; early_rd = 0; bad_width = 0; bad_raddr = 0;
        exp_len = erase ? 6 : 4; tog = 1'b0; gap_last = 0; last_rise = 0;
        m_addr = addr; m_erase = erase; m_data = data; mem_val = stored;
        busy_left = busy_reads; arm = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_erase = erase; req_poll_toggle = toggle;
        req_verify = verify; req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
        got_to = timeout_err; got_ve = verify_err;
        chk("R9 done seen", done, done, 1);
        @(negedge clk);
        chk("R9 done one cycle", !done, done, 0);
    endtask

    task automatic chk_seq(input logic erase, input logic [AW-1:0] addr, input logic [7:0] data);
        string r;
        r = erase ? "R3" : "R2";
        chk({r, " write count"}, wr_n == (erase ? 6 : 4), wr_n, erase ? 6 : 4);
        for (int i = 0; i < (erase ? 6 : 4); i++) begin
            logic [AW-1:0] ea;
            logic [7:0]    ed;
            case (i)
                0: begin ea = AW'(UA); ed = 8'hAA; end
                1: begin ea = AW'(UB); ed = 8'h55; end
                2: begin ea = AW'(UA); ed = erase ? 8'h80 : 8'hA0; end
                3: begin ea = erase ? AW'(UA) : addr; ed = erase ? 8'hAA : data; end
                4: begin ea = AW'(UB); ed = 8'h55; end
                default: begin ea = addr; ed = 8'h30; end
            endcase
            chk({r, " cycle addr"}, wr_a[i] == ea, wr_a[i], ea);
            chk({r, " cycle data"}, wr_d[i] == ed, wr_d[i], ed);
        end
        chk("R2 we pulse width", bad_width == 0, bad_width, 0);
        chk("R4 no early read", early_rd == 0, early_rd, 0);
        chk("R4 read address", bad_raddr == 0, bad_raddr, 0);
    endtask

    task automatic t_reset;
        chk("R1 ce idle", fl_ce_n, fl_ce_n, 1);
        chk("R1 we idle", fl_we_n, fl_we_n, 1);
        chk("R1 oe idle", fl_oe_n, fl_oe_n, 1);
        chk("R1 dq not driven", !fl_dq_oe, fl_dq_oe, 0);
        chk("R1 not busy", !busy, busy, 0);
        chk("R1 no done", !done, done, 0);
    endtask

    task automatic t_program_poll;
        run_op(1'b0, 1'b0, 1'b1, 16'h1234, 8'hA5, 3, 8'hA5);
        chk_seq(1'b0, 16'h1234, 8'hA5);
        chk("R5 program polls+verify", rd_n == 5, rd_n, 5);
        chk("R8 settle gap", gap_last >= SETTLE_CYC, gap_last, SETTLE_CYC);
        chk("R8 verify ok", !got_ve, got_ve, 0);
        chk("R7 no timeout", !got_to, got_to, 0);
    endtask

    task automatic t_program_bit7_low;
        run_op(1'b0, 1'b0, 1'b0, 16'h0042, 8'h3C, 2, 8'h3C);
        chk("R5 program bit7=0 polls", rd_n == 3, rd_n, 3);
        chk("R8 no verify read", !got_ve, got_ve, 0);
    endtask

    task automatic t_erase_poll;
        run_op(1'b1, 1'b0, 1'b1, 16'h3000, 8'h00, 5, 8'hFF);
        chk_seq(1'b1, 16'h3000, 8'h00);
        chk("R5 erase polls+verify", rd_n == 7, rd_n, 7);
        chk("R8 erase verify ok", !got_ve, got_ve, 0);
    endtask

    task automatic t_erase_toggle;
        run_op(1'b1, 1'b1, 1'b0, 16'h7000, 8'h00, 4, 8'hFF);
        chk("R6 toggle erase reads", rd_n == 6, rd_n, 6);
        chk("R6 toggle no timeout", !got_to, got_to, 0);
    endtask

    task automatic t_toggle_first_read;
        run_op(1'b0, 1'b1, 1'b0, 16'h0100, 8'h5A, 0, 8'h5A);
        chk("R6 first read never completes", rd_n == 2, rd_n, 2);
    endtask

    task automatic t_timeout;
        run_op(1'b0, 1'b0, 1'b1, 16'h0200, 8'h11, 1000, 8'h11);
        chk("R7 timeout flag", got_to, got_to, 1);
        chk("R7 read count at timeout", rd_n == MAX_POLLS, rd_n, MAX_POLLS);
        repeat (5) @(negedge clk);
        chk("R9 timeout flag held", timeout_err, timeout_err, 1);
        chk("R1 idle after timeout", fl_ce_n && !busy, busy, 0);
    endtask

    task automatic t_verify_mismatch;
        run_op(1'b0, 1'b0, 1'b1, 16'h0300, 8'h81, 1, 8'h80);
        chk("R9 timeout cleared by new request", !got_to, got_to, 0);
        chk("R8 program verify mismatch", got_ve, got_ve, 1);
        run_op(1'b1, 1'b0, 1'b1, 16'h4000, 8'h00, 2, 8'hEF);
        chk("R8 erase verify mismatch", got_ve, got_ve, 1);
    endtask

    task automatic t_busy_ignore;
        int d0;
        d0 = done_cnt;
        wr_n = 0; rd_n = 0; early_rd = 0; bad_width = 0; bad_raddr = 0;
        exp_len = 6; tog = 1'b0; m_addr = 16'h5000; m_erase = 1'b1; m_data = 8'h00;
        mem_val = 8'hFF; busy_left = 6; arm = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_erase = 1'b1; req_poll_toggle = 1'b0; req_verify = 1'b0;
        req_addr = 16'h5000; req_data = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        req_valid = 1'b1; req_erase = 1'b0; req_addr = 16'h6666; req_data = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R10 writes unchanged", wr_n == 6, wr_n, 6);
        chk("R10 single done", done_cnt - d0 == 1, done_cnt - d0, 1);
        chk("R10 idle afterwards", !busy, busy, 0);
        chk("R10 read address kept", bad_raddr == 0, bad_raddr, 0);
    endtask

    initial begin
        rd_q = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program_poll();
        t_program_bit7_low();
        t_erase_poll();
        t_erase_toggle();
        t_toggle_first_read();
        t_timeout();
        t_verify_mismatch();
        t_busy_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule